// File: doc/BRIEF.md
# Serial Font Memory Burst Reader

This block is the master side of a four-wire serial link to a font memory. A client hands it a 24-bit start address and a byte count. The block drops chip select, clocks out a fixed read frame, and then keeps the serial clock running. Each byte that comes back is passed to the client on a valid/ready stream. The read frame is an opcode of 0x0B, the address with its most significant bit first, and one zero byte for turnaround. The memory moves its internal pointer forward by one after each byte, so a single request can fetch a glyph of any size.

The serial clock is made by dividing the system clock. Both of its phases last a whole number of system cycles, set by a parameter, so the clock frequency limit and the minimum high and low times are met by choosing that parameter. The clock idles low. The block changes its outgoing bit on each falling edge, and the memory takes that bit on the next rising edge. The memory drives its bits after each falling edge, and the block samples them on the rising edge that follows. When the client does not take bytes fast enough, the clock stops, but only between two bytes. After the final byte has been taken, chip select goes high and stays high for a programmable deselect time before a new request is accepted.

Top module: `fontrom_burst_reader`

## Requirements
- R1: While reset is held and just after it, cs_n is 1, sck is 0, out_valid is 0 and req_ready is 1.
- R2: A request accepted with a nonzero count drives cs_n to 0 on the next clock edge while sck stays 0. The first rising sck edge comes no sooner than HALF_DIV system cycles after cs_n falls.
- R3: The first 40 bits on mosi, each taken on a rising sck edge, are 0x0B, then req_addr bits 23 down to 0, then 0x00, all most significant bit first. mosi never changes while sck is 1.
- R4: Starting at rising edge 41, miso is sampled on each rising sck edge. Each group of 8 samples, first sample as bit 7, forms one out_data byte. Successive bytes come from successive memory addresses, wrapping at 24 bits.
- R5: Every sck high phase lasts exactly HALF_DIV system cycles. Every sck low phase lasts at least HALF_DIV cycles.
- R6: A request with count N yields exactly N out_valid transfers. out_last is 1 on the Nth transfer only, and out_last is never 1 without out_valid.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R8: The clock never stops inside a byte. When a byte completes while the output register is still occupied, sck is held at 0 until the register frees. During a long downstream stall, at most one further byte (8 rising edges) is shifted in.
- R9: cs_n stays 0 for the whole transaction and rises only after the final byte has been accepted. One transaction has exactly 8*(5+N) rising sck edges, and sck is 0 whenever cs_n is 1.
- R10: Between two transactions cs_n stays 1 for at least GAP_CYC system cycles.
- R11: A request with count 0 starts no transaction: cs_n stays 1 and req_ready stays 1.
- R12: req_ready is 0 whenever cs_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 24 | Start address in font memory |
| req_len | input | LEN_W | Number of bytes to read |
| cs_n | output | 1 | Active-low chip select to memory |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to memory |
| miso | input | 1 | Serial data from memory |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Received byte |
| out_last | output | 1 | Marks the final byte of the request |

## Verification
The bound checker looks at the clock on every cycle. It checks the width of each high and low phase of sck, that mosi holds still while sck is high, and that sck is low whenever chip select is released. It also checks that req_ready is low during a transaction, that the output stream holds its values while stalled, and that the deselect gap is at least the minimum. Other behaviour can only be shown by the bench's scenarios, which run against a behavioural memory model: the header contents, the byte values and the address increment, the exact count and last flag, the total number of edges, the zero-count case, and how far the clock runs ahead during a long stall.

// File: rtl/frb_pkg.sv
package frb_pkg;
  localparam int          FRB_ADDR_W    = 24;
  localparam logic [7:0]  FRB_READ_OP   = 8'h0B;
  localparam logic [7:0]  FRB_TURN_BYTE = 8'h00;
  localparam int          FRB_HDR_BYTES = 2 + FRB_ADDR_W / 8;
  localparam int          FRB_HDR_BITS  = 8 * FRB_HDR_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_STALL,
    ST_DRAIN,
    ST_GAP
  } frb_state_e;
endpackage

// File: rtl/frb_halfper.sv
module frb_halfper #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/frb_shifter.sv
module frb_shifter #(
  parameter int HDR_BITS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [HDR_BITS-1:0] load_word,
  input  logic                shift,
  input  logic                sample,
  input  logic                miso,
  output logic                mosi,
  output logic [7:0]          rx_byte
);
  logic [HDR_BITS-1:0] tx;
  logic [7:0]          rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx <= '0;
      rx <= '0;
    end else begin
      if (load)       tx <= load_word;
      else if (shift) tx <= {tx[HDR_BITS-2:0], 1'b0};
      if (sample)     rx <= {rx[6:0], miso};
    end
  end

  assign mosi    = tx[HDR_BITS-1];
  assign rx_byte = rx;
endmodule

// File: rtl/fontrom_burst_reader.sv
module fontrom_burst_reader
  import frb_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC  = 12,
  parameter int LEN_W    = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [FRB_ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]      req_len,
  output logic                  cs_n,
  output logic                  sck,
  output logic                  mosi,
  input  logic                  miso,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [7:0]            out_data,
  output logic                  out_last
);
  localparam int GW = $clog2(GAP_CYC + 1);

  frb_state_e        state;
  logic              req_ready_q, cs_n_q, sck_q;
  logic [2:0]        bit_idx;
  logic [2:0]        hdr_left;
  logic [LEN_W-1:0]  remain;
  logic [GW-1:0]     gap_cnt;
  logic              ov_q, ol_q;
  logic [7:0]        od_q;
  logic              tick, start, can_load;
  logic [7:0]        rx_byte;

  assign start    = (state == ST_IDLE) && req_valid && (req_len != '0);
  assign can_load = !ov_q || out_ready;

  frb_halfper #(.HALF_DIV(HALF_DIV)) u_half (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_SHIFT),
    .tick (tick)
  );

  frb_shifter #(.HDR_BITS(FRB_HDR_BITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .load_word ({FRB_READ_OP, req_addr, FRB_TURN_BYTE}),
    .shift     (tick && sck_q),
    .sample    (tick && !sck_q),
    .miso      (miso),
    .mosi      (mosi),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_ready_q <= 1'b1;
      cs_n_q      <= 1'b1;
      sck_q       <= 1'b0;
      bit_idx     <= '0;
      hdr_left    <= '0;
      remain      <= '0;
      gap_cnt     <= '0;
      ov_q        <= 1'b0;
      ol_q        <= 1'b0;
      od_q        <= '0;
    end else begin
      if (ov_q && out_ready) begin
        ov_q <= 1'b0;
        ol_q <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (start) begin
            req_ready_q <= 1'b0;
            cs_n_q      <= 1'b0;
            remain      <= req_len;
            hdr_left    <= 3'(FRB_HDR_BYTES);
            bit_idx     <= '0;
            state       <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
            end else begin
              sck_q <= 1'b0;
              if (bit_idx == 3'd7) begin
                bit_idx <= '0;
                if (hdr_left != '0) begin
                  hdr_left <= hdr_left - 1'b1;
                end else if (can_load) begin
                  ov_q   <= 1'b1;
                  od_q   <= rx_byte;
                  ol_q   <= (remain == LEN_W'(1));
                  remain <= remain - 1'b1;
                  if (remain == LEN_W'(1)) state <= ST_DRAIN;
                end else begin
                  state <= ST_STALL;
                end
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
        end
        ST_STALL: begin
          if (can_load) begin
            ov_q   <= 1'b1;
            od_q   <= rx_byte;
            ol_q   <= (remain == LEN_W'(1));
            remain <= remain - 1'b1;
            state  <= (remain == LEN_W'(1)) ? ST_DRAIN : ST_SHIFT;
          end
        end
        ST_DRAIN: begin
          if (ov_q && out_ready) begin
            cs_n_q  <= 1'b1;
            gap_cnt <= '0;
            state   <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GW'(GAP_CYC - 1)) begin
            req_ready_q <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = req_ready_q;
  assign cs_n      = cs_n_q;
  assign sck       = sck_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;
endmodule

// File: rtl/frb_checker.sv
module frb_checker #(
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC  = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sck,
  input logic       mosi,
  input logic       req_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  logic        sck_seen;
  logic [15:0] run_len;
  logic [15:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_seen <= 1'b0;
      run_len  <= '0;
      hi_len   <= 16'(GAP_CYC);
    end else begin
      sck_seen <= sck;
      if (sck != sck_seen)     run_len <= 16'd1;
      else if (run_len != '1)  run_len <= run_len + 1'b1;
      if (!cs_n)               hi_len <= '0;
      else if (hi_len != '1)   hi_len <= hi_len + 1'b1;
    end
  end

  a_r5_high_width: assert property (@(posedge clk) disable iff (rst)
    (sck_seen && !sck) |-> (run_len == 16'(HALF_DIV)));

  a_r5_low_width: assert property (@(posedge clk) disable iff (rst)
    (!sck_seen && sck) |-> (run_len >= 16'(HALF_DIV)));

  a_r3_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));

  a_r9_sck_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  a_r12_busy: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !req_ready);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r6_last_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r10_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_len >= 16'(GAP_CYC)));
endmodule

bind fontrom_burst_reader frb_checker #(
  .HALF_DIV (HALF_DIV),
  .GAP_CYC  (GAP_CYC)
) u_frb_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .sck       (sck),
  .mosi      (mosi),
  .req_ready (req_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/sim_fontrom_burst_reader.sv
module sim_fontrom_burst_reader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int GAP        = 12;
  localparam int LW         = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [23:0]   req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          cs_n, sck, mosi;
  logic          miso = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;
  logic          out_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  fontrom_burst_reader #(.HALF_DIV(HALF), .GAP_CYC(GAP), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // behavioural font memory
  int          rcount = 0;
  logic [39:0] hdr = '0;
  int          sck_rises = 0;

  always @(posedge sck or negedge cs_n) begin
    if (!sck) begin
      rcount = 0;
      hdr    = '0;
    end else begin
      if (rcount < 40) hdr = {hdr[38:0], mosi};
      rcount++;
      sck_rises++;
    end
  end

  always @(negedge sck) begin
    if (!cs_n && rcount >= 40) begin
      int          k;
      logic [23:0] a;
      logic [7:0]  b;
      k    = rcount - 40;
      a    = hdr[31:8] + 24'(k / 8);
      b    = mem_byte(a);
      miso = b[7 - (k % 8)];
    end
  end

  // scoreboard
  typedef struct { logic [7:0] d; bit last; } exp_t;
  exp_t        exp_q[$];
  int          rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: begin
           lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
           out_ready = lfsr[0];
         end
      default: out_ready = 1'b0;
    endcase
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 extra byte", out_data, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_data == e.d, "R4 data", out_data, e.d);
        check(out_last == e.last, "R6 last flag", out_last, e.last);
      end
    end
  end

  // phase widths and deselect gap
  int hi_run = 0, cs_hi = 0;
  bit cs_prev = 1'b1, txn_seen = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sck) hi_run++;
      else if (hi_run != 0) begin
        check(hi_run == HALF, "R5 high phase", hi_run, HALF);
        hi_run = 0;
      end
      if (cs_n) cs_hi++;
      else begin
        if (cs_prev && txn_seen) check(cs_hi >= GAP, "R10 gap", cs_hi, GAP);
        cs_hi    = 0;
        txn_seen = 1'b1;
      end
      cs_prev = cs_n;
    end
  end

  task automatic start_req(input logic [23:0] a, input int n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_len   = LW'(n);
    for (int i = 0; i < n; i++) exp_q.push_back('{mem_byte(a + 24'(i)), (i == n - 1)});
    @(negedge clk);
    req_valid = 1'b0;
    check(cs_n == 1'b0, "R2 cs_n low", cs_n, 0);
    check(sck == 1'b0, "R2 sck low at start", sck, 0);
    check(req_ready == 1'b0, "R12 busy", req_ready, 0);
  endtask

  task automatic finish_req(input logic [23:0] a, input int n);
    while (!(exp_q.size() == 0 && cs_n)) @(negedge clk);
    check(hdr[39:32] == 8'h0B, "R3 opcode", hdr[39:32], 8'h0B);
    check(hdr[31:8] == a, "R3 address", hdr[31:8], a);
    check(hdr[7:0] == 8'h00, "R3 dummy", hdr[7:0], 0);
    check(rcount == 8 * (5 + n), "R9 edge total", rcount, 8 * (5 + n));
  endtask

  task automatic burst(input logic [23:0] a, input int n, input int mode);
    rdy_mode = mode;
    start_req(a, n);
    finish_req(a, n);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    check(sck == 1'b0, "R1 sck", sck, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);

    // zero count is dropped
    req_valid = 1'b1;
    req_addr  = 24'h000100;
    req_len   = '0;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int lows = 0;
      for (int i = 0; i < 30; i++) begin
        if (!cs_n || !req_ready) lows++;
        @(negedge clk);
      end
      check(lows == 0, "R11 zero count ignored", lows, 0);
    end

    burst(24'h123456, 4, 0);
    burst(24'hFFFFFE, 6, 1);
    burst(24'h000000, 1, 1);

    // long downstream stall
    begin
      int         r0;
      logic [7:0] d0;
      rdy_mode = 2;
      start_req(24'h0A0B0C, 3);
      while (!out_valid) @(negedge clk);
      d0 = out_data;
      r0 = sck_rises;
      repeat (200) @(negedge clk);
      check(sck_rises - r0 == 8, "R8 one byte ahead", sck_rises - r0, 8);
      check(sck == 1'b0, "R8 clock parked low", sck, 0);
      check(out_valid && out_data == d0, "R7 held byte", out_data, d0);
      check(cs_n == 1'b0, "R9 cs held during stall", cs_n, 0);
      rdy_mode = 0;
      finish_req(24'h0A0B0C, 3);
    end

    burst(24'h00FF00, 2, 0);
    burst(24'h7FFFF8, 9, 1);
    repeat (20) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule